// File: doc/BRIEF.md
# Sync Waveform Instruction Sequencer

This block generates video timing strobes from a short stored program instead of from fixed horizontal and vertical counters. A program store of 64 fourteen-bit words is filled through a write port. Once the enable bit in the control register is set, the engine runs one instruction per pixel clock. The program drives three registered outputs: a data-enable bit, a mux-select bit and an 8-bit level.

Each instruction has a 4-bit opcode in bits 13:10 and a 10-bit argument in bits 9:0. Load-type instructions set the outputs. SKIP waits for a number of pixels. Two independent loop units, one for REPEAT and one for REPLAY, allow a pixel loop to sit inside a line loop. Together these describe a whole frame in a handful of words. JUMP, HOLD and STOP control the flow of the program. In frame mode an external frame-sync pulse restarts the program from address 0.

Top module: `wfseq`

## Requirements
- R1: Opcodes are SET=0, RPTSET=1, RPLSET=2, SKIP=3, STOP=4, REPEAT=5, REPLAY=6, JUMP=7, HOLD=8. An executed SET loads level_o from argument bits 7:0, mux_o from bit 8 and de_o from bit 9 at the clock edge that executes it, and takes one pixel period.
- R2: SKIP with count n (bits 9:0) leaves all outputs unchanged for n+1 pixel periods before the next instruction runs. The illegal count 0 behaves as a single period.
- R3: RPTSET acts as SET and records its own address as the repeat start. A REPEAT with count n branches back to that address n times and then falls through. A count of 0 falls through at once.
- R4: RPLSET and REPLAY form a second, independent loop with the same rules. A REPEAT loop may therefore be nested inside a REPLAY loop.
- R5: JUMP continues execution at the address held in argument bits 5:0. Bit 6 is set by convention.
- R6: STOP freezes all outputs and halts the engine. Execution resumes only when the enable bit is cleared and then set again, and it then starts at address 0.
- R7: HOLD loads the outputs as SET does and then halts as STOP does.
- R8: The control register is written through ctrl_wdata, with bit 0 as enable and bit 2 as frame mode. Writing enable low forces de_o low on the second clock edge after the write, and clears the program counter and both loop units. level_o and mux_o keep their values. After reset all three outputs are 0.
- R9: When frame mode is set, a frame_sync pulse restarts the program at address 0, including from a halted state. The first instruction runs on the edge after the pulse. When frame mode is clear, frame_sync has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | 6 | Program store write address |
| prog_data | input | 14 | Instruction word to write |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control value: bit 0 enable, bit 2 frame mode |
| frame_sync | input | 1 | Frame start pulse, used in frame mode |
| de_o | output | 1 | Data-enable output |
| mux_o | output | 1 | Mux-select output |
| level_o | output | 8 | Level output |

## Verification
The assertions assume the following about the inputs:
- Loop instructions are reached only after their matching RPTSET or RPLSET has executed.
- A program is not rewritten while the engine is running it.
- frame_sync is a clean synchronous pulse.

The stimulus meets these conditions in three ways:
- It clears the enable bit before loading every program.
- It writes only programs in which each loop-start instruction comes before its REPEAT or REPLAY.
- It drives frame_sync for exactly one cycle, on the falling clock edge.

// File: rtl/wfseq_pkg.sv
package wfseq_pkg;
  localparam int INSTR_W = 14;
  localparam int OP_W    = 4;
  localparam int ARG_W   = INSTR_W - OP_W;
  localparam int LVL_W   = 8;
  localparam int MUX_BIT = LVL_W;
  localparam int DE_BIT  = LVL_W + 1;
  localparam int NLOOP   = 2;
  localparam int LP_RPT  = 0;
  localparam int LP_RPL  = 1;

  typedef enum logic [OP_W-1:0] {
    OP_SET    = 4'd0,
    OP_RPTSET = 4'd1,
    OP_RPLSET = 4'd2,
    OP_SKIP   = 4'd3,
    OP_STOP   = 4'd4,
    OP_REPEAT = 4'd5,
    OP_REPLAY = 4'd6,
    OP_JUMP   = 4'd7,
    OP_HOLD   = 4'd8
  } op_e;
endpackage

// File: rtl/wfseq_prog_ram.sv
module wfseq_prog_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 14,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  // Zero-filled after reset so unwritten words decode as a level-0 load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/wfseq_loop_unit.sv
module wfseq_loop_unit #(
  parameter int AW = 6,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          mark,
  input  logic [AW-1:0] mark_addr,
  input  logic          hit,
  input  logic [CW-1:0] count,
  output logic          branch,
  output logic [AW-1:0] target
);
  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] start_q, start_n;

  assign branch = hit && (act_q ? (cnt_q != '0) : (count != '0));
  assign target = start_q;

  always_comb begin
    act_n   = act_q;
    cnt_n   = cnt_q;
    start_n = start_q;
    if (clear) begin
      act_n   = 1'b0;
      cnt_n   = '0;
      start_n = '0;
    end else begin
      if (mark) start_n = mark_addr;
      if (hit) begin
        if (!act_q) begin
          if (count != '0) begin
            act_n = 1'b1;
            cnt_n = count - CW'(1);
          end
        end else if (cnt_q == '0) begin
          act_n = 1'b0;
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      start_q <= '0;
    end else begin
      act_q   <= act_n;
      cnt_q   <= cnt_n;
      start_q <= start_n;
    end
  end

  AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_q && cnt_q == '0) |=> !act_q); // R3
  AST_LOOP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clear && !act_q && count != '0) |=> act_q); // R4
endmodule

// File: rtl/wfseq_core.sv
module wfseq_core
  import wfseq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               frame_mode,
  input  logic               frame_sync,
  input  logic [INSTR_W-1:0] instr,
  output logic [AW-1:0]      pc,
  output logic               de,
  output logic               mux,
  output logic [LVL_W-1:0]   level
);
  op_e              op;
  logic [ARG_W-1:0] arg;
  logic             fs, run;
  logic [AW-1:0]    pc_q, pc_n, pc_inc;
  logic             halt_q, halt_n;
  logic             skb_q, skb_n;
  logic [ARG_W-1:0] skc_q, skc_n;
  logic             de_q, de_n, mux_q, mux_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             out_ce;

  logic [NLOOP-1:0] lp_hit, lp_mark, lp_branch;
  logic [AW-1:0]    lp_tgt [NLOOP];

  assign op     = op_e'(instr[INSTR_W-1:ARG_W]);
  assign arg    = instr[ARG_W-1:0];
  assign fs     = en && frame_mode && frame_sync;
  assign run    = en && !fs && !halt_q;
  assign pc_inc = pc_q + AW'(1);

  always_comb begin
    lp_hit  = '0;
    lp_mark = '0;
    lp_hit[LP_RPT]  = run && (op == OP_REPEAT);
    lp_hit[LP_RPL]  = run && (op == OP_REPLAY);
    lp_mark[LP_RPT] = run && (op == OP_RPTSET);
    lp_mark[LP_RPL] = run && (op == OP_RPLSET);
  end

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    wfseq_loop_unit #(.AW(AW), .CW(ARG_W)) u_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!en || fs),
      .mark     (lp_mark[g]),
      .mark_addr(pc_q),
      .hit      (lp_hit[g]),
      .count    (arg),
      .branch   (lp_branch[g]),
      .target   (lp_tgt[g])
    );
  end

  always_comb begin
    pc_n   = pc_q;
    halt_n = halt_q;
    skb_n  = skb_q;
    skc_n  = skc_q;
    de_n   = de_q;
    mux_n  = mux_q;
    lvl_n  = lvl_q;
    if (!en) begin
      pc_n   = '0;
      halt_n = 1'b0;
      skb_n  = 1'b0;
      skc_n  = '0;
      de_n   = 1'b0;
    end else if (fs) begin
      pc_n   = '0;
      halt_n = 1'b0;
      skb_n  = 1'b0;
      skc_n  = '0;
    end else if (!halt_q) begin
      case (op)
        OP_SET, OP_RPTSET, OP_RPLSET, OP_HOLD: begin
          lvl_n = arg[LVL_W-1:0];
          mux_n = arg[MUX_BIT];
          de_n  = arg[DE_BIT];
          if (op == OP_HOLD) halt_n = 1'b1;
          else               pc_n   = pc_inc;
        end
        OP_STOP: halt_n = 1'b1;
        OP_SKIP: begin
          if (skb_q) begin
            if (skc_q == ARG_W'(1)) begin
              skb_n = 1'b0;
              pc_n  = pc_inc;
            end else begin
              skc_n = skc_q - ARG_W'(1);
            end
          end else if (arg != '0) begin
            skb_n = 1'b1;
            skc_n = arg;
          end else begin
            pc_n = pc_inc;
          end
        end
        OP_REPEAT: pc_n = lp_branch[LP_RPT] ? lp_tgt[LP_RPT] : pc_inc;
        OP_REPLAY: pc_n = lp_branch[LP_RPL] ? lp_tgt[LP_RPL] : pc_inc;
        OP_JUMP:   pc_n = arg[AW-1:0];
        default:   pc_n = pc_inc;
      endcase
    end
  end

  assign out_ce = (de_n != de_q) || (mux_n != mux_q) || (lvl_n != lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
      skb_q  <= 1'b0;
      skc_q  <= '0;
    end else begin
      pc_q   <= pc_n;
      halt_q <= halt_n;
      skb_q  <= skb_n;
      skc_q  <= skc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      mux_q <= 1'b0;
      lvl_q <= '0;
    end else if (out_ce) begin
      de_q  <= de_n;
      mux_q <= mux_n;
      lvl_q <= lvl_n;
    end
  end

  assign pc    = pc_q;
  assign de    = de_q;
  assign mux   = mux_q;
  assign level = lvl_q;

  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    skb_q |=> ($stable(lvl_q) && $stable(mux_q))); // R2
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_JUMP) |=> (pc_q == $past(arg[AW-1:0]))); // R5
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && en) |=> ($stable(lvl_q) && $stable(de_q) && $stable(mux_q))); // R6
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> (pc_q == '0 && !halt_q)); // R9
endmodule

// File: rtl/wfseq.sv
module wfseq
  import wfseq_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int EN_BIT    = 0,
  parameter int FRAME_BIT = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int CTRL_W   = FRAME_BIT + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic               frame_sync,
  output logic               de_o,
  output logic               mux_o,
  output logic [LVL_W-1:0]   level_o
);
  logic               en_q, fm_q;
  logic [AW-1:0]      pc;
  logic [INSTR_W-1:0] instr;
  logic               unused_ctrl;

  assign unused_ctrl = ^ctrl_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      fm_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q <= ctrl_wdata[EN_BIT];
      fm_q <= ctrl_wdata[FRAME_BIT];
    end
  end

  wfseq_prog_ram #(.DEPTH(DEPTH), .DW(INSTR_W)) u_ram (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (prog_we),
    .waddr(prog_addr),
    .wdata(prog_data),
    .raddr(pc),
    .rdata(instr)
  );

  wfseq_core #(.AW(AW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .frame_mode(fm_q),
    .frame_sync(frame_sync),
    .instr     (instr),
    .pc        (pc),
    .de        (de_o),
    .mux       (mux_o),
    .level     (level_o)
  );

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pc == '0 && !de_o)); // R8
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (pc == '0)); // R6
endmodule

// File: tb/wfseq_tb.sv
`timescale 1ns/1ps
module wfseq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [5:0]  prog_addr;
  logic [13:0] prog_data;
  logic        ctrl_we;
  logic [2:0]  ctrl_wdata;
  logic        frame_sync;
  logic        de_o, mux_o;
  logic [7:0]  level_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wfseq u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .frame_sync(frame_sync), .de_o(de_o), .mux_o(mux_o), .level_o(level_o)
  );

  // Programs, 8 words each. A: SET/SKIP/RPTSET/REPEAT/STOP. B: nested REPLAY, JUMP, HOLD.
  localparam logic [13:0] PROG [24] = '{
    14'h0211, 14'h0C02, 14'h0522, 14'h0233, 14'h1402, 14'h1000, 14'h0000, 14'h0000,
    14'h0840, 14'h0641, 14'h1401, 14'h1801, 14'h1C46, 14'h00EE, 14'h2355, 14'h0000,
    14'h0210, 14'h0C00, 14'h0220, 14'h1000, 14'h0000, 14'h0000, 14'h0000, 14'h0000
  };

  // Expected {de,mux,level} after each pixel edge since enable: 16 for A, 16 for B
  localparam logic [9:0] EXP [32] = '{
    10'h211, 10'h211, 10'h211, 10'h211, 10'h122, 10'h233, 10'h233, 10'h122,
    10'h233, 10'h233, 10'h122, 10'h233, 10'h233, 10'h233, 10'h233, 10'h233,
    10'h040, 10'h241, 10'h241, 10'h241, 10'h241, 10'h241, 10'h040, 10'h241,
    10'h241, 10'h241, 10'h241, 10'h241, 10'h241, 10'h355, 10'h355, 10'h355
  };

  function automatic logic [9:0] outs();
    return {de_o, mux_o, level_o};
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [2:0] v);
    ctrl_we    = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we    = 1'b0;
  endtask

  // Disable, load program p, enable; returns at the sample point right after enable latches
  task automatic start_prog(input int p);
    write_ctrl(3'b000);
    for (int a = 0; a < 8; a++) begin
      prog_we   = 1'b1;
      prog_addr = 6'(a);
      prog_data = PROG[p*8 + a];
      @(negedge clk);
    end
    prog_we = 1'b0;
    write_ctrl(3'b001);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    ctrl_we = 1'b0; ctrl_wdata = '0; frame_sync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset outputs", outs(), 10'h000);

    // Vector table walk: R1 R2 R3 (program A), R4 R5 R7 (program B)
    for (int i = 0; i < 32; i++) begin
      if (i == 0)  start_prog(0);
      if (i == 16) start_prog(1);
      @(negedge clk);
      chk(i < 16 ? "R1/R2/R3 trace A" : "R4/R5/R7 trace B", outs(), EXP[i]);
    end

    // R7: HOLD stays halted
    repeat (4) @(negedge clk);
    chk("R7 hold frozen", outs(), 10'h355);

    // R9: frame_sync ignored without frame mode
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 sync ignored", outs(), 10'h355);

    // R9: frame mode on, pulse restarts at 0
    write_ctrl(3'b101);
    chk("R9 mode write no restart", outs(), 10'h355);
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    chk("R9 restart edge", outs(), 10'h355);
    @(negedge clk);
    chk("R9 first instr", outs(), 10'h040);
    @(negedge clk);
    chk("R9 second instr", outs(), 10'h241);

    // R8: disable mid-run forces de low two edges after the write
    write_ctrl(3'b000);
    chk("R8 de one edge after write", outs(), 10'h241);
    @(negedge clk);
    chk("R8 de forced low", outs(), 10'h041);
    write_ctrl(3'b001);
    @(negedge clk);
    chk("R8 restart from 0", outs(), 10'h040);

    // R2 zero count, R6 stop and restart (program C)
    start_prog(2);
    @(negedge clk);
    chk("R1 set C0", outs(), 10'h210);
    @(negedge clk);
    chk("R2 skip0 one period", outs(), 10'h210);
    @(negedge clk);
    chk("R2 after skip0", outs(), 10'h220);
    repeat (6) @(negedge clk);
    chk("R6 stop frozen", outs(), 10'h220);
    write_ctrl(3'b000);
    @(negedge clk);
    chk("R6 disabled", outs(), 10'h020);
    write_ctrl(3'b001);
    @(negedge clk);
    chk("R6 resume at 0", outs(), 10'h210);

    finish_run();
  end
endmodule